// File: doc/BRIEF.md
# Serial Channel Clock Source Router

This block picks the receive clock and the transmit clock for one serial channel. It also controls the shared bidirectional clock pin of that channel. An 8-bit mode register is written through a strobe in the system clock domain. Its fields choose each data clock from four candidates: the first external clock pin, the second (bidirectional) clock pin, the baud-rate generator output, and the DPLL output. The DPLL is supplied from outside as two signals: a receive-phase clock and a transmit-phase copy that lags it by 90 degrees, so transmitted and received bit cells line up. The transmit path always takes the lagged copy.

The same register sets the direction of the second clock pin and chooses the signal the pin echoes when it is an output. The candidates for the echo are the crystal oscillator, the selected transmit clock, the baud-rate generator and the receive-phase DPLL. If either data clock is taken from the second pin, the pin is held as an input, whatever the direction bit says. Clock selection is purely combinational from the registered fields. Outputs therefore move only after a register write or a reset, or when a selected candidate clock toggles.

Top module: `ckr_clk_route`

## Requirements
- R1: Register bits 6:5 pick the receive clock: 00 first clock pin, 01 second clock pin input, 10 baud-rate generator, 11 receive-phase DPLL.
- R2: Register bits 4:3 pick the transmit clock with the same codes as R1, except that code 11 selects the transmit-phase (lagged) DPLL signal.
- R3: With neither clock field equal to 01, register bit 2 set to 1 enables the second clock pin as an output and bit 2 at 0 disables it.
- R4: If bits 6:5 or bits 4:3 equal 01, the pin output enable is 0 regardless of bit 2.
- R5: While the pin is an output, bits 1:0 choose what it drives: 00 crystal oscillator, 01 the selected transmit clock, 10 baud-rate generator, 11 receive-phase DPLL.
- R6: With echo code 00 and the oscillator enable input low, the pin drives a constant 1. With the enable high, it follows the oscillator.
- R7: Whenever the output enable is 0, the pin output value is 0, so bits 1:0 have no effect.
- R8: Reset loads the register with 0x08: receive from the first pin, transmit from the second pin, pin as input, echo code 00.
- R9: The register loads bits 6:0 of the write data on the clock edge where the strobe is high and keeps its value otherwise. Bit 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the mode register |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| clk_pin_a | input | 1 | First external clock pin (input only) |
| clk_pin_b_in | input | 1 | Input value of the bidirectional second clock pin |
| brg_clk | input | 1 | Baud-rate generator output |
| dpll_rx_clk | input | 1 | Receive-phase DPLL clock |
| dpll_tx_clk | input | 1 | Transmit-phase DPLL clock, lagging by 90 degrees |
| xtal_clk | input | 1 | Crystal oscillator output |
| xtal_en | input | 1 | Crystal oscillator enabled flag |
| rx_clk | output | 1 | Selected receive clock |
| tx_clk | output | 1 | Selected transmit clock |
| clk_pin_b_out | output | 1 | Value driven onto the second clock pin |
| clk_pin_b_oe | output | 1 | Output enable for the second clock pin |

## Verification
A register write lands on the first rising edge where the strobe is high. Every output is combinational from the register and the candidate clocks, so its new value is due right after that edge. A change on a candidate clock input shows up at the outputs in the same cycle, with no register on the path. The bench drives each write at a falling edge and drops the strobe at the next falling edge, then samples one time unit later. Candidate clock levels are applied as static values and checked after a short settle delay, so no sample sits on an active edge.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

    localparam int unsigned CFG_W   = 8;
    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned SEL_W   = $clog2(NUM_SRC);

    typedef enum logic [SEL_W-1:0] {
        SRC_PIN_A = 2'b00,
        SRC_PIN_B = 2'b01,
        SRC_BRG   = 2'b10,
        SRC_DPLL  = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        ECHO_XTAL = 2'b00,
        ECHO_TXCK = 2'b01,
        ECHO_BRG  = 2'b10,
        ECHO_DPLL = 2'b11
    } echo_sel_e;

    // Field layout matches the decoded bit positions 6:0.
    typedef struct packed {
        src_sel_e  rx_sel;    // bits 6:5
        src_sel_e  tx_sel;    // bits 4:3
        logic      pin_out;   // bit 2
        echo_sel_e echo_sel;  // bits 1:0
    } mode_t;

    localparam int unsigned MODE_W = $bits(mode_t);

    localparam mode_t MODE_RESET = '{
        rx_sel:   SRC_PIN_A,
        tx_sel:   SRC_PIN_B,
        pin_out:  1'b0,
        echo_sel: ECHO_XTAL
    };

endpackage

// File: rtl/ckr_mode_reg.sv
module ckr_mode_reg
    import ckr_pkg::*;
#(
    parameter int unsigned DATA_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output mode_t             mode_q
);

    typedef struct packed {
        mode_t mode;
    } state_t;

    state_t st_d, st_q;

    // Bits above the decoded fields are accepted and dropped.
    logic [DATA_W-MODE_W-1:0] unused_hi;
    assign unused_hi = wr_data[DATA_W-1:MODE_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mode = mode_t'(wr_data[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;

    AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q)); // R9

    AST_LOAD_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_q == mode_t'($past(wr_data[MODE_W-1:0])))); // R9

    AST_RESET_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == MODE_RESET)); // R8

endmodule

// File: rtl/ckr_src_mux.sv
module ckr_src_mux
    import ckr_pkg::*;
#(
    parameter int unsigned N_IN  = NUM_SRC,
    parameter int unsigned SEL_B = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  src,
    input  logic [SEL_B-1:0] sel,
    output logic             clk_o
);

    logic [N_IN-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_leg
            assign hit[gi] = (sel == SEL_B'(gi)) & src[gi];
        end
    endgenerate

    assign clk_o = |hit;

endmodule

// File: rtl/ckr_pin_ctrl.sv
module ckr_pin_ctrl
    import ckr_pkg::*;
(
    input  mode_t mode,
    input  logic  tx_clk_sel,
    input  logic  brg_clk,
    input  logic  dpll_rx_clk,
    input  logic  xtal_clk,
    input  logic  xtal_en,
    output logic  pin_out,
    output logic  pin_oe
);

    logic pin_in_use;
    logic xtal_echo;
    logic echo_val;

    assign pin_in_use = (mode.rx_sel == SRC_PIN_B) || (mode.tx_sel == SRC_PIN_B);
    assign xtal_echo  = xtal_en ? xtal_clk : 1'b1;

    always_comb begin
        unique case (mode.echo_sel)
            ECHO_XTAL: echo_val = xtal_echo;
            ECHO_TXCK: echo_val = tx_clk_sel;
            ECHO_BRG:  echo_val = brg_clk;
            ECHO_DPLL: echo_val = dpll_rx_clk;
            default:   echo_val = 1'b1;
        endcase
    end

    assign pin_oe  = mode.pin_out & ~pin_in_use;
    assign pin_out = pin_oe & echo_val;

endmodule

// File: rtl/ckr_clk_route.sv
module ckr_clk_route
    import ckr_pkg::*;
#(
    parameter int unsigned DATA_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clk_pin_a,
    input  logic              clk_pin_b_in,
    input  logic              brg_clk,
    input  logic              dpll_rx_clk,
    input  logic              dpll_tx_clk,
    input  logic              xtal_clk,
    input  logic              xtal_en,
    output logic              rx_clk,
    output logic              tx_clk,
    output logic              clk_pin_b_out,
    output logic              clk_pin_b_oe
);

    mode_t mode_q;

    ckr_mode_reg #(.DATA_W(DATA_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mode_q  (mode_q)
    );

    // Leg order follows the select encoding: pin A, pin B, BRG, DPLL.
    logic [NUM_SRC-1:0] rx_src, tx_src;
    assign rx_src = {dpll_rx_clk, brg_clk, clk_pin_b_in, clk_pin_a};
    assign tx_src = {dpll_tx_clk, brg_clk, clk_pin_b_in, clk_pin_a};

    ckr_src_mux #(.N_IN(NUM_SRC)) u_rx_mux (
        .src   (rx_src),
        .sel   (mode_q.rx_sel),
        .clk_o (rx_clk)
    );

    ckr_src_mux #(.N_IN(NUM_SRC)) u_tx_mux (
        .src   (tx_src),
        .sel   (mode_q.tx_sel),
        .clk_o (tx_clk)
    );

    ckr_pin_ctrl u_pin (
        .mode        (mode_q),
        .tx_clk_sel  (tx_clk),
        .brg_clk     (brg_clk),
        .dpll_rx_clk (dpll_rx_clk),
        .xtal_clk    (xtal_clk),
        .xtal_en     (xtal_en),
        .pin_out     (clk_pin_b_out),
        .pin_oe      (clk_pin_b_oe)
    );

    AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pin_b_oe |-> mode_q.pin_out); // R3

    AST_PIN_IN_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q.rx_sel == SRC_PIN_B) || (mode_q.tx_sel == SRC_PIN_B)) |-> !clk_pin_b_oe); // R4

    AST_QUIET_WHEN_IN: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_pin_b_oe |-> !clk_pin_b_out); // R7

    AST_XTAL_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_pin_b_oe && mode_q.echo_sel == ECHO_XTAL && !xtal_en) |-> clk_pin_b_out); // R6

    AST_RX_PIN_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.rx_sel == SRC_PIN_A) |-> (rx_clk == clk_pin_a)); // R1

    AST_TX_DPLL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.tx_sel == SRC_DPLL) |-> (tx_clk == dpll_tx_clk)); // R2

endmodule

// File: tb/tb_ckr_clk_route.sv
module tb_ckr_clk_route;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pa = 1'b0, pb = 1'b0, brg = 1'b0, drx = 1'b0, dtx = 1'b0;
    logic       xclk = 1'b0, xen = 1'b0;
    logic       rx_clk, tx_clk, pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    ckr_clk_route dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .clk_pin_a     (pa),
        .clk_pin_b_in  (pb),
        .brg_clk       (brg),
        .dpll_rx_clk   (drx),
        .dpll_tx_clk   (dtx),
        .xtal_clk      (xclk),
        .xtal_en       (xen),
        .rx_clk        (rx_clk),
        .tx_clk        (tx_clk),
        .clk_pin_b_out (pin_out),
        .clk_pin_b_oe  (pin_oe)
    );

    // {mode, {pa,pb,brg,drx,dtx}, {xclk,xen}, expected {rx,tx,out,oe}}
    localparam int NV = 14;
    localparam logic [18:0] VEC [NV] = '{
        {8'h00, 5'b10000, 2'b00, 4'b1100},  // R1 R2 pin A both, pin idle
        {8'h24, 5'b01000, 2'b00, 4'b1000},  // R1 rx from pin B, R4 forced in
        {8'h4C, 5'b00100, 2'b00, 4'b1000},  // R1 brg, R2 tx pin B, R4
        {8'h74, 5'b00010, 2'b11, 4'b1011},  // R1 dpll, R5 R6 xtal live
        {8'h74, 5'b00100, 2'b00, 4'b0111},  // R2 brg, R6 fallback high
        {8'h7D, 5'b00001, 2'b00, 4'b0111},  // R2 lagged dpll, R5 echo tx
        {8'h7D, 5'b00010, 2'b00, 4'b1001},  // R2 tx ignores rx dpll
        {8'h06, 5'b00100, 2'b00, 4'b0011},  // R5 echo brg
        {8'h07, 5'b10010, 2'b00, 4'b1111},  // R5 echo rx dpll
        {8'h07, 5'b00001, 2'b00, 4'b0001},  // R5 echo not tx dpll
        {8'h03, 5'b10010, 2'b00, 4'b1100},  // R3 R7 echo ignored
        {8'h87, 5'b00010, 2'b00, 4'b0011},  // R9 bit 7 ignored
        {8'h58, 5'b00110, 2'b00, 4'b1000},  // R2 tx dpll uses lagged copy
        {8'h74, 5'b00000, 2'b01, 4'b0001}   // R6 enabled xtal low
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic write_mode(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic set_src(input logic [4:0] s, input logic [1:0] x);
        {pa, pb, brg, drx, dtx} = s;
        {xclk, xen} = x;
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        set_src(5'b10000, 2'b00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(rx_clk, 1'b1, "R8 rx from pin A");
        chk(tx_clk, 1'b0, "R8 tx from pin B low");
        chk(pin_oe, 1'b0, "R8 pin input");
        chk(pin_out, 1'b0, "R8 pin quiet");
        set_src(5'b01000, 2'b00);
        chk(tx_clk, 1'b1, "R8 tx from pin B high");
        chk(rx_clk, 1'b0, "R8 rx pin A low");

        for (int i = 0; i < NV; i++) begin
            write_mode(VEC[i][18:11]);
            set_src(VEC[i][10:6], VEC[i][5:4]);
            chk(rx_clk,  VEC[i][3], $sformatf("R1 vec %0d rx", i));
            chk(tx_clk,  VEC[i][2], $sformatf("R2 vec %0d tx", i));
            chk(pin_out, VEC[i][1], $sformatf("R5 vec %0d pin out", i));
            chk(pin_oe,  VEC[i][0], $sformatf("R4 vec %0d pin oe", i));
        end

        // R3 R6: direction bit with xtal echo, oscillator off
        write_mode(8'h04);
        set_src(5'b00000, 2'b00);
        chk(pin_oe, 1'b1, "R3 dir bit enables output");
        chk(pin_out, 1'b1, "R6 xtal off drives high");
        // R3 R7: direction bit cleared
        write_mode(8'h00);
        chk(pin_oe, 1'b0, "R3 dir bit clear");
        chk(pin_out, 1'b0, "R7 no drive as input");

        // R9: no strobe, no change
        write_mode(8'h06);
        set_src(5'b00100, 2'b00);
        @(negedge clk);
        wr_data = 8'h00;
        repeat (4) @(negedge clk);
        #1;
        chk(pin_oe, 1'b1, "R9 held oe without strobe");
        chk(pin_out, 1'b1, "R9 held echo brg without strobe");

        // R8: reset during operation
        write_mode(8'h7F);
        @(negedge clk);
        rst_n = 1'b0;
        set_src(5'b10000, 2'b00);
        chk(pin_oe, 1'b0, "R8 reset forces input");
        chk(rx_clk, 1'b1, "R8 reset rx pin A");
        chk(tx_clk, 1'b0, "R8 reset tx pin B");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(pin_oe, 1'b0, "R8 input after release");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule